// File: doc/BRIEF.md
# Minimal 16-bit Register-Machine Processor

This block is a small 16-bit soft processor that runs a short program held in a 32-entry instruction store. It finishes one instruction per clock. It has sixteen general registers, and it works with a compact set of operations: constant load, add, subtract, unsigned set-if-less-than, branch on a register being zero or non-zero, absolute jump, and store. The processor has no condition flags. A comparison writes 0 or 1 into a general register, and a conditional branch then tests that register.

The core reads its program through a ROM port. It places the program counter on `rom_addr` and takes the addressed word back on `rom_data` in the same cycle. Stores leave on a write port (address, data, strobe) that feeds memory-mapped peripherals, such as an LED register decoded at a fixed address. A store takes its address either from a register or from an 8-bit constant in the instruction.

Instruction word: bits [15:12] hold the opcode, [11:8] field A, [7:4] field B, [3:0] field C, and bits [7:0] form the 8-bit immediate or target.

Top module: `tiny16_core`

## Requirements
- R1: While `rst` is high, `rom_addr` is 0 and `wr_en` is 0. After reset every general register reads as 0.
- R2: Any instruction that is not a taken branch or jump advances the program counter by one per cycle, and it wraps from 31 to 0.
- R3: Opcode 0x1 loads the zero-extended immediate [7:0] into register A.
- R4: Opcode 0x2 writes B + C modulo 2^16 into register A. A may equal a source.
- R5: Opcode 0x3 writes B - C modulo 2^16 into register A. A may equal a source.
- R6: Opcode 0x4 writes 1 into register A when B < C compared unsigned, and 0 otherwise.
- R7: Opcode 0x5 loads target bits [4:0] into the program counter when register A is non-zero. Otherwise it falls through. Target bits [7:5] are ignored.
- R8: Opcode 0x6 loads target bits [4:0] into the program counter when register A is zero. Otherwise it falls through.
- R9: Opcode 0x7 always loads target bits [4:0] into the program counter.
- R10: Opcode 0x8 stores register A at the address held in register B. Opcode 0x9 stores register A at the zero-extended immediate address. `wr_en` is high exactly during the cycle of a store instruction.
- R11: Opcode 0x0 and the opcodes 0xA to 0xF change no register, raise no write, and advance the program counter by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 5 | Program counter, used as the instruction store address |
| rom_data | input | 16 | Instruction word at `rom_addr`, valid in the same cycle |
| wr_addr | output | 16 | Store address |
| wr_data | output | 16 | Store data |
| wr_en | output | 1 | Store strobe, one cycle per store |

## Verification
The assertions assume that `rom_data` is a pure combinational function of `rom_addr` and settles within the cycle, because they decode the opcode straight from the port at the clock edge. The bench meets this by returning words from a bench-held array indexed by `rom_addr`. It changes the program only while reset is held, and it releases reset just after a clock edge so that instruction 0 sees a full cycle. Store results are logged on the falling edge, and every register effect is observed through store instructions.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;

    localparam int XLEN   = 16;
    localparam int ROM_AW = 5;
    localparam int RSEL_W = 4;
    localparam int NREGS  = 1 << RSEL_W;
    localparam int IMM_W  = 8;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_LDI = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_SLT = 4'h4,
        OP_BNZ = 4'h5,
        OP_BZ  = 4'h6,
        OP_JMP = 4'h7,
        OP_STR = 4'h8,
        OP_STI = 4'h9
    } opcode_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT, ALU_PASS} alu_op_e;
    typedef enum logic [1:0] {NXT_SEQ, NXT_IFNZ, NXT_IFZ, NXT_ALWAYS} nxt_e;

    typedef struct packed {
        logic [RSEL_W-1:0] sel_a;
        logic [RSEL_W-1:0] sel_b;
        logic [RSEL_W-1:0] sel_c;
        logic [IMM_W-1:0]  imm;
        alu_op_e           alu;
        logic              rf_we;
        nxt_e              nxt;
        logic              st_en;
        logic              st_imm_addr;
    } dec_t;

    function automatic dec_t decode_word(input logic [XLEN-1:0] w);
        dec_t d;
        d             = '0;
        d.sel_a       = w[11:8];
        d.sel_b       = w[7:4];
        d.sel_c       = w[3:0];
        d.imm         = w[7:0];
        d.alu         = ALU_PASS;
        d.nxt         = NXT_SEQ;
        case (opcode_e'(w[15:12]))
            OP_LDI: d.rf_we = 1'b1;
            OP_ADD: begin d.rf_we = 1'b1; d.alu = ALU_ADD; end
            OP_SUB: begin d.rf_we = 1'b1; d.alu = ALU_SUB; end
            OP_SLT: begin d.rf_we = 1'b1; d.alu = ALU_SLT; end
            OP_BNZ: d.nxt = NXT_IFNZ;
            OP_BZ:  d.nxt = NXT_IFZ;
            OP_JMP: d.nxt = NXT_ALWAYS;
            OP_STR: d.st_en = 1'b1;
            OP_STI: begin d.st_en = 1'b1; d.st_imm_addr = 1'b1; end
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/t16_decode.sv
module t16_decode
    import tiny16_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    always_comb dec = decode_word(instr);
endmodule

// File: rtl/t16_regfile.sv
module t16_regfile
    import tiny16_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int SW = RSEL_W,
    localparam int N = 1 << SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_b,
    input  logic [SW-1:0] sel_c,
    output logic [W-1:0]  val_a,
    output logic [W-1:0]  val_b,
    output logic [W-1:0]  val_c
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wsel == SW'(i))
                regs[i] <= wdata;
        end
    end

    assign val_a = regs[sel_a];
    assign val_b = regs[sel_b];
    assign val_c = regs[sel_c];
endmodule

// File: rtl/t16_alu.sv
module t16_alu
    import tiny16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] k,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            ALU_ADD: res = x + y;
            ALU_SUB: res = x - y;
            ALU_SLT: res = (x < y) ? W'(1) : '0;
            default: res = k;
        endcase
    end
endmodule

// File: rtl/t16_pcunit.sv
module t16_pcunit
    import tiny16_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int W  = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  nxt_e          nxt,
    input  logic [W-1:0]  cond_val,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    logic taken;

    always_comb begin
        case (nxt)
            NXT_IFNZ:   taken = |cond_val;
            NXT_IFZ:    taken = ~|cond_val;
            NXT_ALWAYS: taken = 1'b1;
            default:    taken = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (taken)
            pc <= target;
        else
            pc <= pc + AW'(1);
    end
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
    import tiny16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [XLEN-1:0]   rom_data,
    output logic [XLEN-1:0]   wr_addr,
    output logic [XLEN-1:0]   wr_data,
    output logic              wr_en
);
    dec_t            dec;
    logic [XLEN-1:0] va, vb, vc, imm_ext, alu_res;

    t16_decode u_dec (
        .instr (rom_data),
        .dec   (dec)
    );

    assign imm_ext = zext_imm(dec.imm);

    t16_regfile #(.W(XLEN), .SW(RSEL_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (dec.rf_we),
        .wsel  (dec.sel_a),
        .wdata (alu_res),
        .sel_a (dec.sel_a),
        .sel_b (dec.sel_b),
        .sel_c (dec.sel_c),
        .val_a (va),
        .val_b (vb),
        .val_c (vc)
    );

    t16_alu #(.W(XLEN)) u_alu (
        .op  (dec.alu),
        .x   (vb),
        .y   (vc),
        .k   (imm_ext),
        .res (alu_res)
    );

    t16_pcunit #(.AW(ROM_AW), .W(XLEN)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .nxt      (dec.nxt),
        .cond_val (va),
        .target   (dec.imm[ROM_AW-1:0]),
        .pc       (rom_addr)
    );

    assign wr_en   = dec.st_en & ~rst;
    assign wr_data = va;
    assign wr_addr = dec.st_imm_addr ? imm_ext : vb;
endmodule

// File: rtl/t16_checks.sv
module t16_checks (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rom_addr,
    input logic [3:0]  op_i,
    input logic [7:0]  imm_i,
    input logic [15:0] wr_addr,
    input logic        wr_en
);
    logic is_store, is_flow;
    assign is_store = (op_i == 4'h8) || (op_i == 4'h9);
    assign is_flow  = (op_i == 4'h5) || (op_i == 4'h6) || (op_i == 4'h7);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> !wr_en);

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rom_addr == 5'd0);

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !is_flow |=> rom_addr == $past(rom_addr) + 5'd1);

    // R9
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 4'h7 |=> rom_addr == $past(imm_i[4:0]));

    // R10
    store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en == is_store);

    // R10
    sti_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_i == 4'h9) |-> wr_addr == {8'h00, imm_i});
endmodule

bind tiny16_core t16_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .op_i     (rom_data[15:12]),
    .imm_i    (rom_data[7:0]),
    .wr_addr  (wr_addr),
    .wr_en    (wr_en)
);

// File: tb/sim_tiny16_core.sv
module sim_tiny16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rom_addr;
    logic [15:0] rom_data;
    logic [15:0] wr_addr, wr_data;
    logic        wr_en;

    logic [15:0] rom [32];
    logic [15:0] log_a [256];
    logic [15:0] log_d [256];
    int          log_n = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign rom_data = rom[rom_addr];

    tiny16_core u0 (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
    );

    always @(negedge clk) begin
        if (!rst && wr_en && log_n < 256) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
            log_n = log_n + 1;
        end
    end

    function automatic logic [15:0] i_ldi(input int r, input int k);
        return {4'h1, 4'(r), 8'(k)};
    endfunction
    function automatic logic [15:0] i_rrr(input int op, input int a, input int b, input int c);
        return {4'(op), 4'(a), 4'(b), 4'(c)};
    endfunction
    function automatic logic [15:0] i_br(input int op, input int r, input int t);
        return {4'(op), 4'(r), 8'(t)};
    endfunction
    function automatic logic [15:0] i_str(input int dr, input int ar);
        return {4'h8, 4'(dr), 4'(ar), 4'h0};
    endfunction
    function automatic logic [15:0] i_sti(input int dr, input int k);
        return {4'h9, 4'(dr), 8'(k)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 32; i++) rom[i] = 16'h0000;
    endtask

    // Hold reset over a few edges, check the reset state, release just after an edge.
    task automatic start(output int base);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc in reset", 32'(rom_addr), 32'd0);
        check("R1 strobe in reset", 32'(wr_en), 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        base = log_n;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset_regs();
        int b;
        clear_rom();
        rom[0] = i_sti(0, 8'h10);
        rom[1] = i_sti(7, 8'h11);
        rom[2] = i_sti(15, 8'h12);
        start(b);
        run(5);
        check("R1 write count", 32'(log_n - b), 32'd3);
        for (int i = 0; i < 3; i++) begin
            check("R1 addr", 32'(log_a[b+i]), 32'h10 + 32'(i));
            check("R1 reg zero", 32'(log_d[b+i]), 32'd0);
        end
    endtask

    task automatic t_add_store();
        int b;
        clear_rom();
        rom[0] = i_ldi(0, 5);
        rom[1] = i_ldi(1, 9);
        rom[2] = i_ldi(3, 8'h2A);
        rom[3] = i_rrr(2, 2, 0, 1);
        rom[4] = i_str(2, 3);
        rom[5] = i_ldi(4, 8'hC8);
        rom[6] = i_sti(4, 8'h7F);
        rom[7] = i_rrr(2, 0, 0, 1);
        rom[8] = i_sti(0, 8'h20);
        start(b);
        run(10);
        check("R10 write count", 32'(log_n - b), 32'd3);
        check("R10 reg address", 32'(log_a[b]), 32'h002A);
        check("R4 sum", 32'(log_d[b]), 32'h000E);
        check("R10 const address", 32'(log_a[b+1]), 32'h007F);
        check("R3 zero-extended load", 32'(log_d[b+1]), 32'h00C8);
        check("R4 dest equals source", 32'(log_d[b+2]), 32'h000E);
    endtask

    task automatic t_wrap_compare();
        int b;
        clear_rom();
        rom[0]  = i_ldi(2, 1);
        rom[1]  = i_ldi(1, 0);
        rom[2]  = i_ldi(7, 8'h55);
        rom[3]  = i_ldi(8, 8'h66);
        rom[4]  = i_rrr(3, 0, 1, 2);
        rom[5]  = i_rrr(2, 4, 0, 2);
        rom[6]  = i_rrr(4, 6, 2, 0);
        rom[7]  = i_rrr(4, 7, 0, 2);
        rom[8]  = i_rrr(4, 8, 2, 2);
        rom[9]  = i_sti(0, 8'h40);
        rom[10] = i_sti(4, 8'h41);
        rom[11] = i_sti(6, 8'h42);
        rom[12] = i_sti(7, 8'h43);
        rom[13] = i_sti(8, 8'h44);
        start(b);
        run(15);
        check("R5 write count", 32'(log_n - b), 32'd5);
        check("R5 sub wraps", 32'(log_d[b]), 32'hFFFF);
        check("R4 add wraps", 32'(log_d[b+1]), 32'h0000);
        check("R6 unsigned less", 32'(log_d[b+2]), 32'd1);
        check("R6 not less", 32'(log_d[b+3]), 32'd0);
        check("R6 equal", 32'(log_d[b+4]), 32'd0);
    endtask

    task automatic t_counter();
        int b;
        clear_rom();
        rom[0]  = i_ldi(0, 0);
        rom[1]  = i_ldi(1, 1);
        rom[2]  = i_ldi(2, 16);
        rom[3]  = i_ldi(3, 0);
        rom[4]  = i_ldi(5, 5);
        rom[5]  = i_rrr(2, 0, 0, 1);
        rom[6]  = i_str(0, 5);
        rom[7]  = i_rrr(4, 3, 0, 2);
        rom[8]  = i_br(5, 3, 5);
        rom[9]  = i_rrr(3, 0, 0, 1);
        rom[10] = i_str(0, 5);
        rom[11] = i_rrr(4, 3, 0, 1);
        rom[12] = i_br(6, 3, 9);
        rom[13] = i_br(7, 0, 0);
        start(b);
        run(160);
        check("R7 R8 write count >= 33", 32'(log_n - b >= 33), 32'd1);
        for (int i = 0; i < 32; i++) begin
            int e;
            e = (i < 16) ? i + 1 : 31 - i;
            check("R7 R8 counter value", 32'(log_d[b+i]), 32'(e));
            check("R10 counter address", 32'(log_a[b+i]), 32'h0005);
        end
        check("R9 restart after jump 0", 32'(log_d[b+32]), 32'd1);
    endtask

    task automatic t_branch_edges();
        int b;
        clear_rom();
        rom[0]  = i_ldi(1, 3);
        rom[1]  = i_br(6, 1, 5);
        rom[2]  = i_br(5, 1, 8'hE6);
        rom[3]  = i_sti(1, 8'h60);
        rom[6]  = i_br(6, 0, 9);
        rom[7]  = i_sti(1, 8'h61);
        rom[9]  = i_br(5, 0, 12);
        rom[10] = i_sti(1, 8'h62);
        rom[11] = i_br(7, 0, 11);
        start(b);
        run(20);
        check("R7 R8 single write", 32'(log_n - b), 32'd1);
        check("R8 fallthrough then R7 target bits", 32'(log_a[b]), 32'h0062);
        check("R9 self jump holds pc", 32'(rom_addr), 32'd11);
    endtask

    task automatic t_wrap_illegal();
        int b;
        clear_rom();
        rom[0] = i_ldi(1, 7);
        for (int i = 1; i < 31; i++)
            rom[i] = (i % 3 == 0) ? 16'h0000 : {4'(4'hA + (i % 6)), 4'h1, 8'(i * 5 + 1)};
        rom[31] = i_sti(1, 8'h33);
        start(b);
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            #1;
            if (i < 34) check("R2 pc sequence", 32'(rom_addr), 32'(i % 32));
        end
        check("R11 write count", 32'(log_n - b), 32'd2);
        check("R11 reg untouched", 32'(log_d[b]), 32'd7);
        check("R11 reg untouched 2nd", 32'(log_d[b+1]), 32'd7);
        check("R10 const address", 32'(log_a[b+1]), 32'h0033);
    endtask

    initial begin
        t_reset_regs();
        t_add_store();
        t_wrap_compare();
        t_counter();
        t_branch_edges();
        t_wrap_illegal();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule